// File: doc/BRIEF.md
# Power Mode and Reset Sequencer

This block is the operating-mode controller of a small low-power microcontroller. It sequences the chip from power-on through a two-phase start-up reset into the running state. It moves the chip between running, halted and sleeping. From those state decisions it drives the CPU clock enable, the oscillator enable, the peripheral clock enable and a synchronous system reset. The analog parts (regulator, oscillator, power-check comparator, sleep-counter timing) sit outside and arrive here as single-cycle or level strobes on one free-running clock.

Sleep is a guarded mode. A software write to the sleep bit takes effect only when a separate sleep-enable bit was already 1 before that write. The only way out of sleep is a restart through the full reset sequence. The sleep-enable bit survives that restart, so firmware that reads it after reset can tell a wake-up from a cold start. A power-on indication clears that bit.

The reset sequence has two phases. The first counts oscillator periods and covers reset synchronisation and the power check. The second counts CPU clock periods, where each CPU period lasts a fixed number of oscillator cycles. A fresh reset request during either phase starts the first phase again from zero.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_ni` is low, and after it rises for as long as `pwr_ok_i` stays 0, `mode_o` is 0 (power-on wait). In that state `sys_rst_o`=1, `osc_en_o`=1, `cpu_clk_en_o`=0, `per_clk_en_o`=0 and `sleep_en_o`=0. Mode codes are: 0 power-on wait, 1 synchronise, 2 CPU-clock wait, 3 active, 4 standby, 5 sleep.
- R2: In power-on wait, `pwr_ok_i`=1 at a clock edge moves `mode_o` to 1 at that edge.
- R3: In active, a sleep write (`slp_we_i`=1, `slp_wd_i`=1) enters sleep only if `sleep_en_o` was already 1 before that edge. Otherwise the block stays active. A sleep-enable write in the same cycle does not count.
- R4: In sleep, only an enabled wake source leaves sleep, and it always moves to mode 1. The wake sources are `wake_chg_i` with `wake_chg_en_i`, `pad_rst_i` with `wake_pad_en_i`, and `slp_tmo_i` with `wake_tmo_en_i`. In sleep, watchdog and port resets, halt, interrupts and disabled wake sources have no effect.
- R5: `sleep_en_o` is written from `sen_wd_i` only in active mode when `sen_we_i`=1. Writes in other modes are ignored. It keeps its value through a sleep wake and the reset sequence.
- R6: Mode 1 lasts OSC_CYC cycles (default 8). Mode 2 then lasts CPU_CYC*CPU_DIV cycles (default 16). After that the block is in mode 3.
- R7: A watchdog, pad or port reset request in modes 1 to 4 moves to mode 1 at the next edge with the period count restarted from zero.
- R8: In active, `halt_i` moves to standby (mode 4). In standby `cpu_clk_en_o`=0, `per_clk_en_o`=1, `osc_en_o`=1 and `sys_rst_o`=0. In active both clock enables are 1 and `sys_rst_o`=0.
- R9: In standby, `irq_i`=1 returns to active. In active, `irq_i` has no effect.
- R10: In sleep `osc_en_o`=0, `sys_rst_o`=1, `cpu_clk_en_o`=0 and `per_clk_en_o`=0. In mode 2 `cpu_clk_en_o`=1 and `sys_rst_o`=1.
- R11: In active, a reset request outranks a qualified sleep write, and a qualified sleep write outranks `halt_i`.
- R12: `por_i`=1 moves the block to mode 0 from any mode and clears `sleep_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low flop reset |
| por_i | input | 1 | Power-on indication |
| pwr_ok_i | input | 1 | Power check passed |
| pad_rst_i | input | 1 | External reset pad request |
| wdt_rst_i | input | 1 | Watchdog reset request |
| port_rst_i | input | 1 | Port reset request |
| halt_i | input | 1 | Halt instruction strobe |
| sen_we_i | input | 1 | Sleep-enable bit write strobe |
| sen_wd_i | input | 1 | Sleep-enable bit write data |
| slp_we_i | input | 1 | Sleep bit write strobe |
| slp_wd_i | input | 1 | Sleep bit write data |
| irq_i | input | 1 | Enabled interrupt request |
| slp_tmo_i | input | 1 | Sleep-counter timeout |
| wake_chg_i | input | 1 | Wake-on-change event |
| wake_chg_en_i | input | 1 | Enable wake-on-change |
| wake_pad_en_i | input | 1 | Enable pad wake |
| wake_tmo_en_i | input | 1 | Enable timeout wake |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| sys_rst_o | output | 1 | Synchronous system reset |
| sleep_en_o | output | 1 | Sleep-enable bit value |
| mode_o | output | 3 | Current mode code |

## Verification
Several controls can hit the active state in the same cycle. The bench provokes a sleep-enable write together with a sleep write, a sleep write together with halt, and a watchdog reset together with both. It judges each against the fixed order reset, then qualified sleep, then halt, using the old sleep-enable value. A reset request that lands in the middle of the synchronise phase tests the count restart. A behavioural model in the bench runs a cycle count for each phase, and all outputs are compared against it on every clock.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_SYNC = 3'd1,
    ST_CPUW = 3'd2,
    ST_ACT  = 3'd3,
    ST_STBY = 3'd4,
    ST_SLP  = 3'd5
  } pms_state_e;

  typedef struct packed {
    logic cpu_en;
    logic osc_en;
    logic per_en;
    logic sys_rst;
  } pms_ctl_t;

  function automatic pms_ctl_t ctl_of(pms_state_e s);
    pms_ctl_t c;
    c.cpu_en  = (s == ST_CPUW) || (s == ST_ACT);
    c.osc_en  = (s != ST_SLP);
    c.per_en  = (s == ST_ACT) || (s == ST_STBY);
    c.sys_rst = (s == ST_POR) || (s == ST_SYNC) || (s == ST_CPUW) || (s == ST_SLP);
    return c;
  endfunction
endpackage

// File: rtl/pms_req_decode.sv
module pms_req_decode #(
  parameter int NRST  = 3,
  parameter int NWAKE = 3
) (
  input  logic [NRST-1:0]  rst_src_i,
  input  logic [NWAKE-1:0] wake_src_i,
  input  logic [NWAKE-1:0] wake_en_i,
  output logic             rst_req_o,
  output logic             wake_req_o
);
  logic [NWAKE-1:0] wake_hit;

  for (genvar i = 0; i < NWAKE; i++) begin : g_wake
    assign wake_hit[i] = wake_src_i[i] & wake_en_i[i];
  end

  assign rst_req_o  = |rst_src_i;
  assign wake_req_o = |wake_hit;
endmodule

// File: rtl/pms_ctl_regs.sv
module pms_ctl_regs
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  pms_state_e state_i,
  input  logic       sen_we_i,
  input  logic       sen_wd_i,
  input  logic       slp_we_i,
  input  logic       slp_wd_i,
  output logic       sleep_en_o,
  output logic       sleep_go_o
);
  logic sen_q;
  logic wr_ok;

  assign wr_ok = (state_i == ST_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sen_q <= 1'b0;
    else if (por_i)             sen_q <= 1'b0;
    else if (wr_ok && sen_we_i) sen_q <= sen_wd_i;
  end

  // old enable value qualifies the sleep write
  assign sleep_go_o = wr_ok && slp_we_i && slp_wd_i && sen_q;
  assign sleep_en_o = sen_q;

  p_sen_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !(wr_ok && sen_we_i)) |=> $stable(sen_q));
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int OSC_CYC = 8,
  parameter int CPU_CYC = 8,
  parameter int CPU_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       pwr_ok_i,
  input  logic       rst_req_i,
  input  logic       wake_req_i,
  input  logic       sleep_go_i,
  input  logic       halt_i,
  input  logic       irq_i,
  output pms_state_e state_q_o,
  output pms_state_e state_d_o
);
  localparam int MAXC = (OSC_CYC > CPU_CYC) ? OSC_CYC : CPU_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pms_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          restart, clr, tick;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    unique case (state_q)
      ST_POR:  if (pwr_ok_i) state_d = ST_SYNC;
      ST_SYNC: begin
        if (rst_req_i) restart = 1'b1;
        else if (cnt_q == CW'(OSC_CYC - 1)) state_d = ST_CPUW;
      end
      ST_CPUW: begin
        if (rst_req_i) state_d = ST_SYNC;
        else if (tick && cnt_q == CW'(CPU_CYC - 1)) state_d = ST_ACT;
      end
      ST_ACT: begin
        if (rst_req_i)       state_d = ST_SYNC;
        else if (sleep_go_i) state_d = ST_SLP;
        else if (halt_i)     state_d = ST_STBY;
      end
      ST_STBY: begin
        if (rst_req_i)  state_d = ST_SYNC;
        else if (irq_i) state_d = ST_ACT;
      end
      ST_SLP:  if (wake_req_i) state_d = ST_SYNC;
      default: state_d = ST_POR;
    endcase
    if (por_i) state_d = ST_POR;
  end

  assign clr = restart || (state_d != state_q);

  if (CPU_DIV > 1) begin : g_div
    localparam int DW = $clog2(CPU_DIV + 1);
    logic [DW-1:0] div_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               div_q <= '0;
      else if (clr || state_q != ST_CPUW)        div_q <= '0;
      else if (div_q == DW'(CPU_DIV - 1))        div_q <= '0;
      else                                       div_q <= div_q + 1'b1;
    end
    assign tick = (div_q == DW'(CPU_DIV - 1));
  end else begin : g_nodiv
    assign tick = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (clr) cnt_q <= '0;
      else if (state_q == ST_SYNC || (state_q == ST_CPUW && tick)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  p_cpuw_from_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CPUW && $past(state_q) != ST_CPUW) |-> $past(state_q) == ST_SYNC);
  p_act_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && $past(state_q) != ST_ACT) |->
      ($past(state_q) == ST_CPUW || $past(state_q) == ST_STBY));
  p_sleep_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SLP |=> (state_q == ST_SLP || state_q == ST_SYNC || state_q == ST_POR));
  p_por_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> state_q == ST_POR);
endmodule

// File: rtl/pms_out_reg.sv
module pms_out_reg
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pms_state_e state_d_i,
  output pms_ctl_t   ctl_o
);
  pms_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= ctl_of(ST_POR);
    else         ctl_q <= ctl_of(state_d_i);
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int OSC_CYC = 8,
  parameter int CPU_CYC = 8,
  parameter int CPU_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       pwr_ok_i,
  input  logic       pad_rst_i,
  input  logic       wdt_rst_i,
  input  logic       port_rst_i,
  input  logic       halt_i,
  input  logic       sen_we_i,
  input  logic       sen_wd_i,
  input  logic       slp_we_i,
  input  logic       slp_wd_i,
  input  logic       irq_i,
  input  logic       slp_tmo_i,
  input  logic       wake_chg_i,
  input  logic       wake_chg_en_i,
  input  logic       wake_pad_en_i,
  input  logic       wake_tmo_en_i,
  output logic       cpu_clk_en_o,
  output logic       osc_en_o,
  output logic       per_clk_en_o,
  output logic       sys_rst_o,
  output logic       sleep_en_o,
  output logic [2:0] mode_o
);
  pms_state_e state_q, state_d;
  pms_ctl_t   ctl;
  logic       rst_req, wake_req, sleep_go;

  pms_req_decode #(.NRST(3), .NWAKE(3)) u_req (
    .rst_src_i  ({pad_rst_i, wdt_rst_i, port_rst_i}),
    .wake_src_i ({wake_chg_i, pad_rst_i, slp_tmo_i}),
    .wake_en_i  ({wake_chg_en_i, wake_pad_en_i, wake_tmo_en_i}),
    .rst_req_o  (rst_req),
    .wake_req_o (wake_req)
  );

  pms_ctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .state_i    (state_q),
    .sen_we_i   (sen_we_i),
    .sen_wd_i   (sen_wd_i),
    .slp_we_i   (slp_we_i),
    .slp_wd_i   (slp_wd_i),
    .sleep_en_o (sleep_en_o),
    .sleep_go_o (sleep_go)
  );

  pms_fsm #(.OSC_CYC(OSC_CYC), .CPU_CYC(CPU_CYC), .CPU_DIV(CPU_DIV)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .pwr_ok_i   (pwr_ok_i),
    .rst_req_i  (rst_req),
    .wake_req_i (wake_req),
    .sleep_go_i (sleep_go),
    .halt_i     (halt_i),
    .irq_i      (irq_i),
    .state_q_o  (state_q),
    .state_d_o  (state_d)
  );

  pms_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .ctl_o     (ctl)
  );

  assign cpu_clk_en_o = ctl.cpu_en;
  assign osc_en_o     = ctl.osc_en;
  assign per_clk_en_o = ctl.per_en;
  assign sys_rst_o    = ctl.sys_rst;
  assign mode_o       = state_q;

  p_sleep_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && !sleep_en_o) |=> state_q != ST_SLP);
  p_stby_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_STBY |-> (!cpu_clk_en_o && per_clk_en_o && !sys_rst_o));
  p_sleep_osc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SLP |-> (!osc_en_o && sys_rst_o && !per_clk_en_o));
  p_rst_prio_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACT && rst_req && !por_i) |=> state_q == ST_SYNC);
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int CLK_P   = 10;
  localparam int OSC_CYC = 8;
  localparam int CPU_CYC = 8;
  localparam int CPU_DIV = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic por_i = 0, pwr_ok_i = 0, pad_rst_i = 0, wdt_rst_i = 0, port_rst_i = 0;
  logic halt_i = 0, sen_we_i = 0, sen_wd_i = 0, slp_we_i = 0, slp_wd_i = 0, irq_i = 0;
  logic slp_tmo_i = 0, wake_chg_i = 0, wake_chg_en_i = 0, wake_pad_en_i = 0, wake_tmo_en_i = 0;
  logic cpu_clk_en_o, osc_en_o, per_clk_en_o, sys_rst_o, sleep_en_o;
  logic [2:0] mode_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st = 0, m_cnt = 0, m_sen = 0;
  string cur_tag = "R1";

  always #(CLK_P/2) clk_i = ~clk_i;

  pwr_mode_seq #(.OSC_CYC(OSC_CYC), .CPU_CYC(CPU_CYC), .CPU_DIV(CPU_DIV)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    int rq, wk, go;
    rq = pad_rst_i | wdt_rst_i | port_rst_i;
    wk = (wake_chg_i & wake_chg_en_i) | (pad_rst_i & wake_pad_en_i) | (slp_tmo_i & wake_tmo_en_i);
    if (por_i) begin m_st = 0; m_cnt = 0; m_sen = 0; return; end
    case (m_st)
      0: if (pwr_ok_i) begin m_st = 1; m_cnt = 0; end
      1: if (rq) m_cnt = 0;
         else begin m_cnt++; if (m_cnt == OSC_CYC) begin m_st = 2; m_cnt = 0; end end
      2: if (rq) begin m_st = 1; m_cnt = 0; end
         else begin m_cnt++; if (m_cnt == CPU_CYC*CPU_DIV) begin m_st = 3; m_cnt = 0; end end
      3: begin
        go = slp_we_i & slp_wd_i & m_sen;
        if (sen_we_i) m_sen = sen_wd_i;
        if (rq) begin m_st = 1; m_cnt = 0; end
        else if (go) m_st = 5;
        else if (halt_i) m_st = 4;
      end
      4: if (rq) begin m_st = 1; m_cnt = 0; end else if (irq_i) m_st = 3;
      5: if (wk) begin m_st = 1; m_cnt = 0; end
      default: m_st = 0;
    endcase
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin m_st = 0; m_cnt = 0; m_sen = 0; end
    else model_step();
    #(CLK_P/4);
    chk({cur_tag, " mode"}, mode_o, m_st);
    chk({cur_tag, " enables"},
        {cpu_clk_en_o, osc_en_o, per_clk_en_o, sys_rst_o, sleep_en_o},
        {m_st == 2 || m_st == 3, m_st != 5, m_st == 3 || m_st == 4,
         m_st == 0 || m_st == 1 || m_st == 2 || m_st == 5, m_sen[0]});
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tk(int n); repeat (n) @(negedge clk_i); endtask

  task automatic wait_act();
    for (int i = 0; i < 64 && mode_o != 3'd3; i++) @(negedge clk_i);
    chk("R6 reached active", mode_o, 3);
  endtask

  task automatic go_sleep();
    slp_we_i = 1; slp_wd_i = 1; tk(1); slp_we_i = 0; slp_wd_i = 0;
  endtask

  initial begin
    cur_tag = "R1";
    tk(3);
    chk("R1 mode in reset", mode_o, 0);
    chk("R1 sys_rst in reset", sys_rst_o, 1);
    chk("R1 osc_en in reset", osc_en_o, 1);
    chk("R1 sleep_en in reset", sleep_en_o, 0);
    rst_ni = 1; tk(5);
    chk("R1 waits for power check", mode_o, 0);

    cur_tag = "R2"; pwr_ok_i = 1; tk(1);
    chk("R2 power check to sync", mode_o, 1);
    cur_tag = "R6"; tk(7);
    chk("R6 sync last cycle", mode_o, 1);
    tk(1); chk("R6 cpu wait entered", mode_o, 2);
    chk("R10 cpu clock on in cpu wait", cpu_clk_en_o, 1);
    tk(15); chk("R6 cpu wait last cycle", mode_o, 2);
    tk(1); chk("R6 active after sequence", mode_o, 3);

    cur_tag = "R3"; go_sleep();
    chk("R3 sleep write ignored", mode_o, 3);
    sen_we_i = 1; sen_wd_i = 1; slp_we_i = 1; slp_wd_i = 1; tk(1);
    sen_we_i = 0; slp_we_i = 0; slp_wd_i = 0;
    chk("R3 same-cycle enable does not qualify", mode_o, 3);
    chk("R5 enable written in active", sleep_en_o, 1);
    cur_tag = "R5"; sen_we_i = 1; sen_wd_i = 0; tk(1); sen_we_i = 0;
    chk("R5 enable cleared in active", sleep_en_o, 0);

    cur_tag = "R9"; irq_i = 1; tk(2); irq_i = 0;
    chk("R9 irq ignored in active", mode_o, 3);
    cur_tag = "R8"; halt_i = 1; tk(1); halt_i = 0;
    chk("R8 halt to standby", mode_o, 4);
    chk("R8 cpu clock off", cpu_clk_en_o, 0);
    chk("R8 peripheral clock on", per_clk_en_o, 1);
    tk(3); chk("R8 standby holds", mode_o, 4);
    cur_tag = "R5"; sen_we_i = 1; sen_wd_i = 1; tk(1); sen_we_i = 0;
    chk("R5 write ignored in standby", sleep_en_o, 0);
    cur_tag = "R9"; irq_i = 1; tk(1); irq_i = 0;
    chk("R9 irq wakes standby", mode_o, 3);

    cur_tag = "R7"; halt_i = 1; tk(1); halt_i = 0;
    port_rst_i = 1; tk(1); port_rst_i = 0;
    chk("R7 port reset from standby", mode_o, 1);
    tk(4); wdt_rst_i = 1; tk(1); wdt_rst_i = 0;
    tk(7); chk("R7 sync restarted", mode_o, 1);
    tk(1); chk("R7 cpu wait after restart", mode_o, 2);
    tk(5); pad_rst_i = 1; tk(1); pad_rst_i = 0;
    chk("R7 pad reset in cpu wait", mode_o, 1);
    wait_act();

    cur_tag = "R10"; sen_we_i = 1; sen_wd_i = 1; tk(1); sen_we_i = 0;
    go_sleep();
    chk("R10 sleep entered", mode_o, 5);
    chk("R10 oscillator off", osc_en_o, 0);
    chk("R10 reset held", sys_rst_o, 1);
    cur_tag = "R4";
    wake_chg_i = 1; tk(2); wake_chg_i = 0;
    port_rst_i = 1; wdt_rst_i = 1; irq_i = 1; halt_i = 1; pad_rst_i = 1; tk(2);
    port_rst_i = 0; wdt_rst_i = 0; irq_i = 0; halt_i = 0; pad_rst_i = 0;
    slp_tmo_i = 1; tk(1); slp_tmo_i = 0;
    chk("R4 disabled sources ignored", mode_o, 5);
    wake_tmo_en_i = 1; slp_tmo_i = 1; tk(1); slp_tmo_i = 0; wake_tmo_en_i = 0;
    chk("R4 timeout wake to sync", mode_o, 1);
    wait_act();
    chk("R5 enable kept over wake", sleep_en_o, 1);

    cur_tag = "R11"; halt_i = 1; slp_we_i = 1; slp_wd_i = 1; tk(1);
    halt_i = 0; slp_we_i = 0; slp_wd_i = 0;
    chk("R11 sleep beats halt", mode_o, 5);
    wake_pad_en_i = 1; pad_rst_i = 1; tk(1); pad_rst_i = 0; wake_pad_en_i = 0;
    chk("R4 pad wake to sync", mode_o, 1);
    wait_act();
    wdt_rst_i = 1; halt_i = 1; slp_we_i = 1; slp_wd_i = 1; tk(1);
    wdt_rst_i = 0; halt_i = 0; slp_we_i = 0; slp_wd_i = 0;
    chk("R11 reset beats sleep", mode_o, 1);
    wait_act();
    cur_tag = "R4"; go_sleep();
    wake_chg_en_i = 1; wake_chg_i = 1; tk(1); wake_chg_i = 0; wake_chg_en_i = 0;
    chk("R4 change wake to sync", mode_o, 1);
    wait_act();

    cur_tag = "R12"; por_i = 1; tk(2);
    chk("R12 power-on to wait", mode_o, 0);
    chk("R12 enable cleared", sleep_en_o, 0);
    por_i = 0; tk(1);
    chk("R2 sync after power-on", mode_o, 1);
    tk(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule